// File: doc/BRIEF.md
# Logical, Shift and Sign-Extend Unit

This block is a combinational 32-bit execution unit. It performs bitwise logic, logical shifts and sign extension. The first operand is always a register word. The second operand is either another register word or a 16-bit immediate. The immediate can be aligned to the low halfword or to the high halfword of the word, and the other halfword is filled with zeros. Before a logic operation, the unit can complement either operand on its own. This lets a single AND, OR or XOR path also produce and-with-complement, nand-style and equivalence results.

Shifts move the first operand left or right and always fill with zeros. The shift count comes from the low five bits of the immediate or from the low six bits of the second register. A register count of 32 or more clears the word. Sign extension widens the low byte or the low halfword of the first operand to a full word. Every operation also produces a zero flag. The unit is meant to sit in the execute stage of an integer pipeline, next to the adder and the multiplier.

Top module: `lsx_unit`

## Requirements
- R1: With `use_imm_i`=0, `inv_a_i`=0 and `inv_b_i`=0, op codes 0, 1 and 2 return the bitwise AND, OR and XOR of `reg_a_i` and `reg_b_i`.
- R2: With `use_imm_i`=1 and `imm_hi_i`=0, the second logic operand is `imm_i` in bits 15:0, with bits 31:16 zero.
- R3: With `use_imm_i`=1 and `imm_hi_i`=1, the second logic operand is `imm_i` in bits 31:16, with bits 15:0 zero.
- R4: `inv_a_i` complements the first operand and `inv_b_i` complements the aligned second operand, before the logic operation. Both inputs have no effect on op codes 3 to 7.
- R5: Op code 3 shifts `reg_a_i` left by the shift count and fills the vacated low bits with zeros.
- R6: Op code 4 shifts `reg_a_i` right by the shift count and fills the vacated high bits with zeros.
- R7: The shift count is `imm_i[4:0]` when `use_imm_i`=1, and `reg_b_i[5:0]` otherwise. `imm_hi_i` has no effect on shifts.
- R8: A register shift count from 32 to 63 gives a zero result for both shift directions.
- R9: Op code 5 returns `reg_a_i[7:0]` sign-extended to 32 bits.
- R10: Op code 6 returns `reg_a_i[15:0]` sign-extended to 32 bits.
- R11: `zero_o` is 1 exactly when `result_o` is all zeros, for every op code.
- R12: Op code 7 is unused and returns a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation: 0 AND, 1 OR, 2 XOR, 3 shift left, 4 shift right, 5 byte extend, 6 halfword extend, 7 unused |
| reg_a_i | input | 32 | First register operand |
| reg_b_i | input | 32 | Second register operand, or the register shift count |
| imm_i | input | 16 | Immediate operand or immediate shift count |
| use_imm_i | input | 1 | Use the immediate in place of `reg_b_i` |
| imm_hi_i | input | 1 | Align the immediate to the high halfword |
| inv_a_i | input | 1 | Complement the first logic operand |
| inv_b_i | input | 1 | Complement the second logic operand |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | Result is all zeros |

## Verification
The case that is hardest to reach from the ports is one where several controls combine. Examples are a complemented, high-aligned immediate, whose zero-filled low half turns into ones, and a register shift count with bit 5 set. Random words seldom hit either case together with a result that is exactly zero. The stimulus therefore sweeps every combination of source, alignment and complement controls against a fixed set of edge-valued words. It also walks every shift count from 0 to 63 in both directions. A separate pass toggles the complement and alignment controls on shift and extend operations and compares against the same operation with those controls clear.

// File: rtl/lsx_pkg.sv
package lsx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned HALF_W  = 16;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned SHAMT_W = 6;
    localparam int unsigned OP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHR  = 3'd4,
        OP_EXTB = 3'd5,
        OP_EXTH = 3'd6,
        OP_NONE = 3'd7
    } lsx_op_e;

    typedef enum logic [1:0] {
        LG_AND  = 2'd0,
        LG_OR   = 2'd1,
        LG_XOR  = 2'd2,
        LG_ZERO = 2'd3
    } lsx_logic_e;

    typedef enum logic [1:0] {
        RS_LOGIC = 2'd0,
        RS_SHIFT = 2'd1,
        RS_EXT   = 2'd2,
        RS_ZERO  = 2'd3
    } lsx_rsel_e;

    typedef struct packed {
        lsx_logic_e lop;
        lsx_rsel_e  rsel;
        logic       shr;
        logic       ext_half;
    } lsx_ctrl_t;

    function automatic lsx_ctrl_t decode_op(lsx_op_e op);
        lsx_ctrl_t c;
        c.lop      = LG_ZERO;
        c.rsel     = RS_ZERO;
        c.shr      = 1'b0;
        c.ext_half = 1'b0;
        case (op)
            OP_AND:  begin c.lop = LG_AND; c.rsel = RS_LOGIC; end
            OP_OR:   begin c.lop = LG_OR;  c.rsel = RS_LOGIC; end
            OP_XOR:  begin c.lop = LG_XOR; c.rsel = RS_LOGIC; end
            OP_SHL:  c.rsel = RS_SHIFT;
            OP_SHR:  begin c.rsel = RS_SHIFT; c.shr = 1'b1; end
            OP_EXTB: c.rsel = RS_EXT;
            OP_EXTH: begin c.rsel = RS_EXT; c.ext_half = 1'b1; end
            default: c.rsel = RS_ZERO;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lsx_operand_sel.sv
module lsx_operand_sel #(
    parameter int unsigned DATA_W = lsx_pkg::WORD_W,
    parameter int unsigned IMM_W  = lsx_pkg::HALF_W
) (
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic              imm_hi,
    input  logic              inv_a,
    input  logic              inv_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int unsigned PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_word;
    logic [DATA_W-1:0] raw_b;

    // The halfword that does not hold the immediate is filled with zeros
    always_comb begin
        if (imm_hi) imm_word = {imm, {PAD_W{1'b0}}};
        else        imm_word = {{PAD_W{1'b0}}, imm};
    end

    assign raw_b  = use_imm ? imm_word : reg_b;
    assign opnd_a = inv_a ? ~reg_a : reg_a;
    assign opnd_b = inv_b ? ~raw_b : raw_b;

endmodule

// File: rtl/lsx_logic.sv
module lsx_logic #(
    parameter int unsigned DATA_W = lsx_pkg::WORD_W
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  lsx_pkg::lsx_logic_e sel,
    output logic [DATA_W-1:0]  y
);
    import lsx_pkg::*;

    always_comb begin
        case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/lsx_shifter.sv
module lsx_shifter #(
    parameter int unsigned DATA_W  = lsx_pkg::WORD_W,
    parameter int unsigned SHAMT_W = lsx_pkg::SHAMT_W
) (
    input  logic [DATA_W-1:0]  val,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               right,
    output logic [DATA_W-1:0]  y
);
    localparam int unsigned LOG2 = $clog2(DATA_W);

    logic [DATA_W-1:0] stage [0:LOG2];
    logic              over;

    assign stage[0] = val;

    // One stage per count bit, each moving by a power of two
    for (genvar k = 0; k < LOG2; k++) begin : g_stage
        localparam int unsigned DIST = 1 << k;
        always_comb begin
            if (!amt[k])    stage[k+1] = stage[k];
            else if (right) stage[k+1] = stage[k] >> DIST;
            else            stage[k+1] = stage[k] << DIST;
        end
    end

    // Counts at or beyond the word width push every bit out
    if (SHAMT_W > LOG2) begin : g_over
        assign over = |amt[SHAMT_W-1:LOG2];
    end else begin : g_no_over
        assign over = 1'b0;
    end

    assign y = over ? '0 : stage[LOG2];

endmodule

// File: rtl/lsx_sext.sv
module lsx_sext #(
    parameter int unsigned DATA_W = lsx_pkg::WORD_W,
    parameter int unsigned HALF_W = lsx_pkg::HALF_W,
    parameter int unsigned BYTE_W = lsx_pkg::BYTE_W
) (
    input  logic [HALF_W-1:0] val,
    input  logic              from_half,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned BYTE_PAD = DATA_W - BYTE_W;
    localparam int unsigned HALF_PAD = DATA_W - HALF_W;

    logic [DATA_W-1:0] ext_b;
    logic [DATA_W-1:0] ext_h;

    assign ext_b = {{BYTE_PAD{val[BYTE_W-1]}}, val[BYTE_W-1:0]};
    assign ext_h = {{HALF_PAD{val[HALF_W-1]}}, val};
    assign y     = from_half ? ext_h : ext_b;

endmodule

// File: rtl/lsx_unit.sv
module lsx_unit #(
    parameter int unsigned DATA_W  = lsx_pkg::WORD_W,
    parameter int unsigned IMM_W   = lsx_pkg::HALF_W,
    parameter int unsigned SHAMT_W = lsx_pkg::SHAMT_W
) (
    input  logic [lsx_pkg::OP_W-1:0] op_i,
    input  logic [DATA_W-1:0]        reg_a_i,
    input  logic [DATA_W-1:0]        reg_b_i,
    input  logic [IMM_W-1:0]         imm_i,
    input  logic                     use_imm_i,
    input  logic                     imm_hi_i,
    input  logic                     inv_a_i,
    input  logic                     inv_b_i,
    output logic [DATA_W-1:0]        result_o,
    output logic                     zero_o
);
    import lsx_pkg::*;

    localparam int unsigned LOG2 = $clog2(DATA_W);

    lsx_ctrl_t         ctrl;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] logic_y;
    logic [DATA_W-1:0] shift_y;
    logic [DATA_W-1:0] ext_y;
    logic [SHAMT_W-1:0] shamt;

    assign ctrl = decode_op(lsx_op_e'(op_i));

    lsx_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .reg_a   (reg_a_i),
        .reg_b   (reg_b_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .imm_hi  (imm_hi_i),
        .inv_a   (inv_a_i),
        .inv_b   (inv_b_i),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b)
    );

    lsx_logic #(.DATA_W(DATA_W)) u_logic (
        .a   (opnd_a),
        .b   (opnd_b),
        .sel (ctrl.lop),
        .y   (logic_y)
    );

    // The immediate count is limited to the word width, the register count is not
    assign shamt = use_imm_i ? SHAMT_W'(imm_i[LOG2-1:0]) : reg_b_i[SHAMT_W-1:0];

    lsx_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .val   (reg_a_i),
        .amt   (shamt),
        .right (ctrl.shr),
        .y     (shift_y)
    );

    lsx_sext #(.DATA_W(DATA_W), .HALF_W(IMM_W), .BYTE_W(BYTE_W)) u_sext (
        .val       (reg_a_i[IMM_W-1:0]),
        .from_half (ctrl.ext_half),
        .y         (ext_y)
    );

    always_comb begin
        case (ctrl.rsel)
            RS_LOGIC: result_o = logic_y;
            RS_SHIFT: result_o = shift_y;
            RS_EXT:   result_o = ext_y;
            default:  result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;

endmodule

// File: rtl/lsx_unit_chk.sv
module lsx_unit_chk #(
    parameter int unsigned DATA_W  = lsx_pkg::WORD_W,
    parameter int unsigned SHAMT_W = lsx_pkg::SHAMT_W
) (
    input logic [lsx_pkg::OP_W-1:0] op_i,
    input logic [DATA_W-1:0]        reg_a_i,
    input logic [SHAMT_W-1:0]       cnt_reg,
    input logic                     use_imm_i,
    input logic                     imm_hi_i,
    input logic                     inv_a_i,
    input logic                     inv_b_i,
    input logic [DATA_W-1:0]        result_o,
    input logic                     zero_o
);
    import lsx_pkg::*;

    localparam int unsigned HPAD = DATA_W - HALF_W;
    localparam int unsigned BPAD = DATA_W - BYTE_W;

    lsx_op_e op;
    logic    plain;
    assign op    = lsx_op_e'(op_i);
    assign plain = !inv_a_i && !inv_b_i;

    always_comb begin
        AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag mismatch"); // R11
        if (op == OP_AND && !inv_a_i)
            AST_AND_SUBSET: assert ((result_o & ~reg_a_i) == '0) else $error("AND grew bits"); // R1
        if (op == OP_OR && !inv_a_i)
            AST_OR_COVER: assert ((result_o & reg_a_i) == reg_a_i) else $error("OR lost bits"); // R1
        if (op == OP_OR && use_imm_i && !imm_hi_i && plain)
            AST_IMM_LO_FILL: assert (result_o[DATA_W-1:HALF_W] == reg_a_i[DATA_W-1:HALF_W]) else $error("low imm fill"); // R2
        if (op == OP_XOR && use_imm_i && imm_hi_i && plain)
            AST_IMM_HI_FILL: assert (result_o[HALF_W-1:0] == reg_a_i[HALF_W-1:0]) else $error("high imm fill"); // R3
        if ((op == OP_SHL || op == OP_SHR) && !use_imm_i && cnt_reg[SHAMT_W-1])
            AST_SHIFT_OVER: assert (result_o == '0) else $error("oversized shift"); // R8
        if (op == OP_EXTB)
            AST_EXTB_SIGN: assert (result_o == {{BPAD{reg_a_i[BYTE_W-1]}}, reg_a_i[BYTE_W-1:0]}) else $error("byte extend"); // R9
        if (op == OP_EXTH)
            AST_EXTH_SIGN: assert (result_o == {{HPAD{reg_a_i[HALF_W-1]}}, reg_a_i[HALF_W-1:0]}) else $error("half extend"); // R10
        if (op == OP_NONE)
            AST_NONE_ZERO: assert (zero_o) else $error("unused op nonzero"); // R12
    end

endmodule

bind lsx_unit lsx_unit_chk #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) i_lsx_unit_chk (
    .op_i      (op_i),
    .reg_a_i   (reg_a_i),
    .cnt_reg   (reg_b_i[SHAMT_W-1:0]),
    .use_imm_i (use_imm_i),
    .imm_hi_i  (imm_hi_i),
    .inv_a_i   (inv_a_i),
    .inv_b_i   (inv_b_i),
    .result_o  (result_o),
    .zero_o    (zero_o)
);

// File: tb/test_lsx_unit.sv
`timescale 1ns/1ps
module test_lsx_unit;

    logic        clk = 1'b0;
    logic [2:0]  op_i;
    logic [31:0] reg_a_i, reg_b_i;
    logic [15:0] imm_i;
    logic        use_imm_i, imm_hi_i, inv_a_i, inv_b_i;
    logic [31:0] result_o;
    logic        zero_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    lsx_unit i_lsx_unit (
        .op_i(op_i), .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .imm_i(imm_i),
        .use_imm_i(use_imm_i), .imm_hi_i(imm_hi_i), .inv_a_i(inv_a_i),
        .inv_b_i(inv_b_i), .result_o(result_o), .zero_o(zero_o)
    );

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h0000_0001;
            4: return 32'hA5A5_5A5A;
            5: return 32'h0000_8080;
            6: return 32'h7FFF_FF7F;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] model(int op, logic [31:0] a, logic [31:0] b,
                                          logic [15:0] imm, logic ui, logic hi,
                                          logic ia, logic ib);
        logic [31:0] x, y;
        longint unsigned n, p;
        x = ia ? ~a : a;
        if (ui) y = hi ? 32'(imm) * 32'd65536 : 32'(imm);
        else    y = b;
        if (ib) y = ~y;
        n = ui ? longint'(imm % 16'd32) : longint'(b % 32'd64);
        p = 64'd1 << n;
        case (op)
            0: return x & y;
            1: return x | y;
            2: return x ^ y;
            3: return (n >= 32) ? 32'd0 : 32'((longint'(a) * p) % 64'h1_0000_0000);
            4: return (n >= 32) ? 32'd0 : 32'(longint'(a) / p);
            5: return a[7]  ? 32'(a % 256)   + 32'hFFFF_FF00 : 32'(a % 256);
            6: return a[15] ? 32'(a % 65536) + 32'hFFFF_0000 : 32'(a % 65536);
            default: return 32'd0;
        endcase
    endfunction

    task automatic drive(int op, logic [31:0] a, logic [31:0] b, logic [15:0] imm,
                         logic ui, logic hi, logic ia, logic ib);
        op_i = 3'(op); reg_a_i = a; reg_b_i = b; imm_i = imm;
        use_imm_i = ui; imm_hi_i = hi; inv_a_i = ia; inv_b_i = ib;
        #1;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic run_one(string tag, int op, logic [31:0] a, logic [31:0] b,
                           logic [15:0] imm, logic ui, logic hi, logic ia, logic ib);
        logic [31:0] e;
        drive(op, a, b, imm, ui, hi, ia, ib);
        e = model(op, a, b, imm, ui, hi, ia, ib);
        check(tag, result_o, e);
        check("R11", 32'(zero_o), 32'(e == 32'd0));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog got=%0d exp=<100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        // Idle inputs: AND of zeros
        run_one("R1", 0, 32'd0, 32'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);

        // Logic ops: every source, alignment and complement combination (R1 R2 R3 R4)
        for (int op = 0; op < 3; op++)
            for (int m = 0; m < 16; m++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++) begin
                        string tag;
                        logic ui, hi, ia, ib;
                        ui = m[0]; hi = m[1]; ia = m[2]; ib = m[3];
                        if (ia || ib)  tag = "R4";
                        else if (!ui)  tag = "R1";
                        else if (hi)   tag = "R3";
                        else           tag = "R2";
                        run_one(tag, op, pat(i), pat(j), pat(j)[15:0] ^ pat(i)[31:16],
                                ui, hi, ia, ib);
                    end

        // Shifts: every register count 0..63 and immediate count 0..31 (R5 R6 R7 R8)
        for (int op = 3; op < 5; op++)
            for (int n = 0; n < 64; n++)
                for (int i = 0; i < 8; i++) begin
                    string tag;
                    tag = (n >= 32) ? "R8" : ((op == 3) ? "R5" : "R6");
                    run_one(tag, op, pat(i), {pat(i)[31:6], 6'(n)}, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0);
                    if (n < 32)
                        run_one("R7", op, pat(i), pat(7 - i), {pat(i)[15:5], 5'(n)},
                                1'b1, n[0], 1'b0, 1'b0);
                end

        // Sign extension across all byte values and halfword edges (R9 R10)
        for (int v = 0; v < 256; v++)
            run_one("R9", 5, {pat(v % 8)[31:8], 8'(v)}, 32'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int v = 0; v < 256; v++)
            run_one("R10", 6, {pat(v % 8)[31:16], 8'(v), 8'(255 - v)}, 32'd0, 16'd0,
                    1'b0, 1'b0, 1'b0, 1'b0);

        // Unused op code (R12)
        for (int i = 0; i < 8; i++)
            run_one("R12", 7, pat(i), pat(7 - i), 16'hFFFF, i[0], i[1], i[2], 1'b1);

        // Complement and alignment controls ignored outside logic ops (R4 R7)
        for (int op = 3; op < 8; op++)
            for (int i = 0; i < 8; i++)
                for (int m = 1; m < 8; m++) begin
                    logic [31:0] base;
                    drive(op, pat(i), {26'd0, 6'(i * 5)}, 16'(i * 3), 1'b0, 1'b0, 1'b0, 1'b0);
                    base = result_o;
                    drive(op, pat(i), {26'd0, 6'(i * 5)}, 16'(i * 3), 1'b0, m[2], m[0], m[1]);
                    check("R4", result_o, base);
                end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule